// File: doc/BRIEF.md
# Presence-Detect Byte Stream Checker

This block sits behind a two-wire serial reader that fetches the configuration bytes of a memory module. Each byte arrives with a one-cycle valid strobe and its index. Indices may come in any order. The block keeps a record of which of the first 64 indices it has taken, and it sums indices 0 to 62 modulo 256 as they arrive. It compares that sum with the byte stored at index 63. At the same time it captures the geometry and timing fields, and it decodes the cycle-time bytes from their whole/tenth nibble code into tenths of a nanosecond.

Once every index from 0 to 63 has been taken, the block raises a one-cycle done pulse. In the same cycle it publishes the checksum result and selects a CAS latency. The lowest latency whose minimum cycle time fits the target clock period wins. A synchronous clear makes the block ready for the next module.

Top module: `spd_stream_decoder`

## Requirements
- R1: After reset, and after a cycle with `clr` high, `done`, `checksum_ok`, `type_unsupported`, `ecc_present`, `cas_latency` and every captured field read zero. `clr` takes priority over a byte strobed in the same cycle.
- R2: `checksum_ok` is 1 when the low 8 bits of the sum of the bytes at indices 0..62 equal the byte at index 63, and 0 otherwise. It is updated together with `done` and holds until the next reset or clear.
- R3: `done` is high for exactly one cycle. It rises one clock after the edge that accepts the last index of 0..63 not yet taken, whatever order the indices arrive in. It is never high before that, and it does not pulse again until a clear.
- R4: A repeated index is ignored. The first value taken for an index is the one that counts, for both the checksum and the captured fields.
- R5: Indices of 64 and above are ignored.
- R6: `type_unsupported` is 1 when the byte at index 2 is anything other than 0x04, and 0 when it is 0x04.
- R7: `row_bits` (index 3), `col_bits` (index 4), `module_banks` (index 5), `data_width` (index 6, where 0x40 means 64 and 0x48 means 72) and `burst_mask` (index 16) copy their bytes. `ecc_present` is 1 exactly when the byte at index 11 is 0x02.
- R8: `tck_cl3_tenths` (index 9) and `tck_cl2_tenths` (index 23) hold upper nibble x 10 + lower nibble, in tenths of a ns (0xA0 gives 100, 0x75 gives 75). The code 0xFF means "not supported" and gives 0.
- R9: `trp_ns` (index 27), `trcd_ns` (index 29) and `tras_ns` (index 30) copy their bytes as whole nanoseconds.
- R10: When `done` rises, `cas_latency` becomes 2 if bit 1 of the byte at index 18 is set, index 23 is not 0xFF, and its decoded time is no greater than `target_tenths`. Otherwise it becomes 3 if bit 2 of index 18 is set, index 9 is not 0xFF, and its decoded time is no greater than the target. Otherwise it is 0.
- R11: Bytes taken before a clear do not count towards the checksum, the done condition or the fields after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous restart for the next module |
| byte_valid | input | 1 | Strobe: byte_idx/byte_data valid this cycle |
| byte_idx | input | 8 | Index of the incoming byte |
| byte_data | input | 8 | Value of the incoming byte |
| target_tenths | input | 8 | Target clock period in tenths of a ns |
| done | output | 1 | One-cycle completion pulse |
| checksum_ok | output | 1 | Checksum comparison result |
| type_unsupported | output | 1 | Memory type byte is not 0x04 |
| row_bits | output | 8 | Row address bit count |
| col_bits | output | 8 | Column address bit count |
| module_banks | output | 8 | Module bank count |
| data_width | output | 8 | Module data width |
| ecc_present | output | 1 | Module carries check bits |
| burst_mask | output | 8 | Supported burst length mask |
| cas_latency | output | 2 | Selected latency: 2, 3 or 0 for none |
| tck_cl3_tenths | output | 8 | Minimum cycle at CL3, tenths of a ns |
| tck_cl2_tenths | output | 8 | Minimum cycle at CL2, tenths of a ns |
| trp_ns | output | 8 | Row precharge time, ns |
| trcd_ns | output | 8 | Row-to-column delay, ns |
| tras_ns | output | 8 | Minimum row active time, ns |

## Verification
The captured fields and the decoded cycle times are registered on the edge that accepts their byte, so they are final by the time `done` rises. The bench reads them in the `done` cycle. `done`, `checksum_ok` and `cas_latency` come one edge later than the acceptance of the last missing index. The bench drives each byte for one cycle between falling edges. Right after that byte's accepting edge it checks that `done` is still low. It expects the pulse at the next falling edge and expects it gone at the one after. Ignored bytes are checked over the two cycles that follow them, through the unchanged fields and the absence of a second pulse.

// File: rtl/spd_dec_pkg.sv
package spd_dec_pkg;

  typedef enum logic [1:0] {
    CL_NONE  = 2'd0,
    CL_TWO   = 2'd2,
    CL_THREE = 2'd3
  } cas_sel_e;

  // whole/tenth nibble code to tenths of a nanosecond
  function automatic logic [7:0] nib_to_tenths(input logic [7:0] code);
    logic [7:0] whole;
    logic [7:0] frac;
    whole = {4'd0, code[7:4]};
    frac  = {4'd0, code[3:0]};
    return (whole << 3) + (whole << 1) + frac;
  endfunction

endpackage

// File: rtl/spd_cksum_track.sv
module spd_cksum_track #(
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 8,
  parameter int N_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              byte_valid,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [DATA_W-1:0] byte_data,
  output logic              take_o,
  output logic              all_seen_o,
  output logic              sum_match_o
);
  localparam int SEL_W  = $clog2(N_BYTES);
  localparam int CK_IDX = N_BYTES - 1;

  logic [N_BYTES-1:0] seen_q;
  logic [DATA_W-1:0]  sum_q;
  logic [DATA_W-1:0]  stored_q;
  logic [SEL_W-1:0]   sel;
  logic               in_range;

  assign sel      = byte_idx[SEL_W-1:0];
  assign in_range = {1'b0, byte_idx} < (IDX_W+1)'(N_BYTES);
  assign take_o   = byte_valid && in_range && !seen_q[sel];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen_q   <= '0;
      sum_q    <= '0;
      stored_q <= '0;
    end else if (take_o) begin
      seen_q[sel] <= 1'b1;
      if (sel == SEL_W'(CK_IDX)) stored_q <= byte_data;
      else                       sum_q    <= sum_q + byte_data;
    end
  end

  assign all_seen_o  = &seen_q;
  assign sum_match_o = (sum_q == stored_q);

  // R2: with no strobe the running sum holds
  assert_sum_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !byte_valid) |=> $stable(sum_q));

  // R4: the record of taken indices only grows until a clear
  assert_seen_grows_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ($countones(seen_q) >= $past($countones(seen_q))));

endmodule

// File: rtl/spd_field_capture.sv
module spd_field_capture
  import spd_dec_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [DATA_W-1:0] byte_data,
  output logic              type_bad_o,
  output logic [DATA_W-1:0] row_o,
  output logic [DATA_W-1:0] col_o,
  output logic [DATA_W-1:0] banks_o,
  output logic [DATA_W-1:0] width_o,
  output logic              ecc_o,
  output logic [DATA_W-1:0] burst_o,
  output logic [DATA_W-1:0] clmask_o,
  output logic [7:0]        tck3_o,
  output logic              tck3_ok_o,
  output logic [7:0]        tck2_o,
  output logic              tck2_ok_o,
  output logic [DATA_W-1:0] trp_o,
  output logic [DATA_W-1:0] trcd_o,
  output logic [DATA_W-1:0] tras_o
);
  localparam logic [IDX_W-1:0] P_TYPE  = IDX_W'(2);
  localparam logic [IDX_W-1:0] P_ROW   = IDX_W'(3);
  localparam logic [IDX_W-1:0] P_COL   = IDX_W'(4);
  localparam logic [IDX_W-1:0] P_BANKS = IDX_W'(5);
  localparam logic [IDX_W-1:0] P_WIDTH = IDX_W'(6);
  localparam logic [IDX_W-1:0] P_TCK3  = IDX_W'(9);
  localparam logic [IDX_W-1:0] P_CFG   = IDX_W'(11);
  localparam logic [IDX_W-1:0] P_BURST = IDX_W'(16);
  localparam logic [IDX_W-1:0] P_CLMSK = IDX_W'(18);
  localparam logic [IDX_W-1:0] P_TCK2  = IDX_W'(23);
  localparam logic [IDX_W-1:0] P_TRP   = IDX_W'(27);
  localparam logic [IDX_W-1:0] P_TRCD  = IDX_W'(29);
  localparam logic [IDX_W-1:0] P_TRAS  = IDX_W'(30);
  localparam logic [DATA_W-1:0] V_SDRAM = DATA_W'(8'h04);
  localparam logic [DATA_W-1:0] V_ECC   = DATA_W'(8'h02);
  localparam logic [DATA_W-1:0] V_NONE  = DATA_W'(8'hFF);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      type_bad_o <= 1'b0; row_o  <= '0; col_o  <= '0; banks_o <= '0;
      width_o    <= '0;   ecc_o  <= 1'b0; burst_o <= '0; clmask_o <= '0;
      tck3_o     <= '0;   tck3_ok_o <= 1'b0; tck2_o <= '0; tck2_ok_o <= 1'b0;
      trp_o      <= '0;   trcd_o <= '0; tras_o <= '0;
    end else if (take) begin
      case (byte_idx)
        P_TYPE:  type_bad_o <= (byte_data != V_SDRAM);
        P_ROW:   row_o      <= byte_data;
        P_COL:   col_o      <= byte_data;
        P_BANKS: banks_o    <= byte_data;
        P_WIDTH: width_o    <= byte_data;
        P_CFG:   ecc_o      <= (byte_data == V_ECC);
        P_BURST: burst_o    <= byte_data;
        P_CLMSK: clmask_o   <= byte_data;
        P_TRP:   trp_o      <= byte_data;
        P_TRCD:  trcd_o     <= byte_data;
        P_TRAS:  tras_o     <= byte_data;
        P_TCK3: begin
          tck3_ok_o <= (byte_data != V_NONE);
          tck3_o    <= (byte_data == V_NONE) ? 8'd0 : nib_to_tenths(8'(byte_data));
        end
        P_TCK2: begin
          tck2_ok_o <= (byte_data != V_NONE);
          tck2_o    <= (byte_data == V_NONE) ? 8'd0 : nib_to_tenths(8'(byte_data));
        end
        default: ;
      endcase
    end
  end

  // R6: a taken type byte of 0x04 leaves the flag low
  assert_type_ok_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && take && byte_idx == P_TYPE && byte_data == V_SDRAM) |=> !type_bad_o);

  // R8: an unsupported code never decodes to a nonzero time
  assert_tck_none_R8: assert property (@(posedge clk) disable iff (rst)
    (!tck2_ok_o) |-> (tck2_o == 8'd0));

endmodule

// File: rtl/spd_cas_select.sv
module spd_cas_select
  import spd_dec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] clmask,
  input  logic [7:0]        tck2,
  input  logic              tck2_ok,
  input  logic [7:0]        tck3,
  input  logic              tck3_ok,
  input  logic [7:0]        target,
  output cas_sel_e          sel_o
);
  logic fit2, fit3;

  assign fit2 = clmask[1] && tck2_ok && (tck2 <= target);
  assign fit3 = clmask[2] && tck3_ok && (tck3 <= target);

  always_comb begin
    if (fit2)      sel_o = CL_TWO;
    else if (fit3) sel_o = CL_THREE;
    else           sel_o = CL_NONE;
  end

endmodule

// File: rtl/spd_stream_decoder.sv
module spd_stream_decoder
  import spd_dec_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 8,
  parameter int N_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              byte_valid,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [7:0]        target_tenths,
  output logic              done,
  output logic              checksum_ok,
  output logic              type_unsupported,
  output logic [DATA_W-1:0] row_bits,
  output logic [DATA_W-1:0] col_bits,
  output logic [DATA_W-1:0] module_banks,
  output logic [DATA_W-1:0] data_width,
  output logic              ecc_present,
  output logic [DATA_W-1:0] burst_mask,
  output logic [1:0]        cas_latency,
  output logic [7:0]        tck_cl3_tenths,
  output logic [7:0]        tck_cl2_tenths,
  output logic [DATA_W-1:0] trp_ns,
  output logic [DATA_W-1:0] trcd_ns,
  output logic [DATA_W-1:0] tras_ns
);
  logic              take, all_seen, sum_match;
  logic [DATA_W-1:0] clmask;
  logic              tck3_ok, tck2_ok;
  cas_sel_e          cas_next;
  logic              finished_q, done_q, ok_q;
  logic [1:0]        cas_q;

  spd_cksum_track #(.IDX_W(IDX_W), .DATA_W(DATA_W), .N_BYTES(N_BYTES)) u_track (
    .clk(clk), .rst(rst), .clr(clr), .byte_valid(byte_valid),
    .byte_idx(byte_idx), .byte_data(byte_data),
    .take_o(take), .all_seen_o(all_seen), .sum_match_o(sum_match)
  );

  spd_field_capture #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_fields (
    .clk(clk), .rst(rst), .clr(clr), .take(take),
    .byte_idx(byte_idx), .byte_data(byte_data),
    .type_bad_o(type_unsupported), .row_o(row_bits), .col_o(col_bits),
    .banks_o(module_banks), .width_o(data_width), .ecc_o(ecc_present),
    .burst_o(burst_mask), .clmask_o(clmask),
    .tck3_o(tck_cl3_tenths), .tck3_ok_o(tck3_ok),
    .tck2_o(tck_cl2_tenths), .tck2_ok_o(tck2_ok),
    .trp_o(trp_ns), .trcd_o(trcd_ns), .tras_o(tras_ns)
  );

  spd_cas_select #(.DATA_W(DATA_W)) u_cas (
    .clmask(clmask), .tck2(tck_cl2_tenths), .tck2_ok(tck2_ok),
    .tck3(tck_cl3_tenths), .tck3_ok(tck3_ok),
    .target(target_tenths), .sel_o(cas_next)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      finished_q <= 1'b0;
      done_q     <= 1'b0;
      ok_q       <= 1'b0;
      cas_q      <= 2'd0;
    end else begin
      done_q <= 1'b0;
      if (all_seen && !finished_q) begin
        finished_q <= 1'b1;
        done_q     <= 1'b1;
        ok_q       <= sum_match;
        cas_q      <= cas_next;
      end
    end
  end

  assign done        = done_q;
  assign checksum_ok = ok_q;
  assign cas_latency = cas_q;

  // R3: the completion pulse lasts one cycle
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: completion only once every index has been taken
  assert_done_all_seen_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> all_seen);

  // R2: the checksum result only turns on with the completion pulse
  assert_ok_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(checksum_ok) |-> done);

  // R10: the published latency is one of the legal codes
  assert_cas_code_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (cas_latency != 2'd1));

endmodule

// File: tb/spd_stream_decoder_tb.sv
module spd_stream_decoder_tb;
  logic       clk = 1'b0;
  logic       rst, clr, byte_valid;
  logic [7:0] byte_idx, byte_data, target_tenths;
  logic       done, checksum_ok, type_unsupported, ecc_present;
  logic [7:0] row_bits, col_bits, module_banks, data_width, burst_mask;
  logic [1:0] cas_latency;
  logic [7:0] tck_cl3_tenths, tck_cl2_tenths, trp_ns, trcd_ns, tras_ns;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] img [64];

  always #5 clk = ~clk;

  spd_stream_decoder u_dut (
    .clk(clk), .rst(rst), .clr(clr), .byte_valid(byte_valid),
    .byte_idx(byte_idx), .byte_data(byte_data), .target_tenths(target_tenths),
    .done(done), .checksum_ok(checksum_ok), .type_unsupported(type_unsupported),
    .row_bits(row_bits), .col_bits(col_bits), .module_banks(module_banks),
    .data_width(data_width), .ecc_present(ecc_present), .burst_mask(burst_mask),
    .cas_latency(cas_latency), .tck_cl3_tenths(tck_cl3_tenths),
    .tck_cl2_tenths(tck_cl2_tenths), .trp_ns(trp_ns), .trcd_ns(trcd_ns),
    .tras_ns(tras_ns)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int dec(input logic [7:0] c);
    if (c == 8'hFF) return 0;
    return int'(c[7:4]) * 10 + int'(c[3:0]);
  endfunction

  function automatic int exp_cas(input int tgt);
    if (img[18][1] && img[23] != 8'hFF && dec(img[23]) <= tgt) return 2;
    if (img[18][2] && img[9]  != 8'hFF && dec(img[9])  <= tgt) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] sum62();
    logic [7:0] s = 8'd0;
    for (int i = 0; i < 63; i++) s = s + img[i];
    return s;
  endfunction

  task automatic std_image();
    for (int i = 0; i < 64; i++) img[i] = 8'hFF;
    img[0] = 8'h80; img[1] = 8'h08; img[2] = 8'h04; img[3] = 8'h0D;
    img[4] = 8'h0A; img[5] = 8'h01; img[6] = 8'h40; img[7] = 8'h00;
    img[8] = 8'h01; img[9] = 8'hA0; img[10] = 8'h60; img[11] = 8'h00;
    img[12] = 8'h82; img[13] = 8'h08; img[14] = 8'h00; img[15] = 8'h01;
    img[16] = 8'h0F; img[17] = 8'h04; img[18] = 8'h06; img[19] = 8'h01;
    img[20] = 8'h01; img[21] = 8'h00; img[22] = 8'h0E; img[23] = 8'hA0;
    img[24] = 8'h60; img[27] = 8'h14; img[28] = 8'h10; img[29] = 8'h14;
    img[30] = 8'h32; img[31] = 8'h40; img[62] = 8'h12;
    img[63] = sum62();
  endtask

  task automatic send(input int idx, input logic [7:0] val);
    byte_valid = 1'b1; byte_idx = 8'(idx); byte_data = val;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R1 done after clear", int'(done), 0);
    chk("R1 ok after clear", int'(checksum_ok), 0);
    chk("R1 row after clear", int'(row_bits), 0);
    chk("R1 cas after clear", int'(cas_latency), 0);
    chk("R1 tck3 after clear", int'(tck_cl3_tenths), 0);
  endtask

  // last byte was accepted at the edge just passed
  task automatic expect_done(input string tag, input int exp_ok, input int tgt);
    chk({tag, " R3 no early done"}, int'(done), 0);
    @(negedge clk);
    chk({tag, " R3 done pulse"}, int'(done), 1);
    chk({tag, " R2 checksum"}, int'(checksum_ok), exp_ok);
    chk({tag, " R10 cas"}, int'(cas_latency), exp_cas(tgt));
    chk({tag, " R6 type"}, int'(type_unsupported), int'(img[2] != 8'h04));
    chk({tag, " R7 row"}, int'(row_bits), int'(img[3]));
    chk({tag, " R7 col"}, int'(col_bits), int'(img[4]));
    chk({tag, " R7 banks"}, int'(module_banks), int'(img[5]));
    chk({tag, " R7 width"}, int'(data_width), int'(img[6]));
    chk({tag, " R7 ecc"}, int'(ecc_present), int'(img[11] == 8'h02));
    chk({tag, " R7 burst"}, int'(burst_mask), int'(img[16]));
    chk({tag, " R8 tck3"}, int'(tck_cl3_tenths), dec(img[9]));
    chk({tag, " R8 tck2"}, int'(tck_cl2_tenths), dec(img[23]));
    chk({tag, " R9 trp"}, int'(trp_ns), int'(img[27]));
    chk({tag, " R9 trcd"}, int'(trcd_ns), int'(img[29]));
    chk({tag, " R9 tras"}, int'(tras_ns), int'(img[30]));
    @(negedge clk);
    chk({tag, " R3 done drops"}, int'(done), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 done at reset", int'(done), 0);
    chk("R1 ok at reset", int'(checksum_ok), 0);
    chk("R1 type at reset", int'(type_unsupported), 0);
    chk("R1 width at reset", int'(data_width), 0);
    chk("R1 cas at reset", int'(cas_latency), 0);
  endtask

  task automatic t_in_order();
    std_image();
    target_tenths = 8'd100;
    do_clear();
    for (int i = 0; i < 64; i++) send(i, img[i]);
    expect_done("inorder", 1, 100);
  endtask

  task automatic t_stride_bad_sum();
    std_image();
    img[2] = 8'h05; img[6] = 8'h48; img[11] = 8'h02; img[23] = 8'hF0;
    img[63] = sum62() ^ 8'h01;
    target_tenths = 8'd100;
    do_clear();
    for (int k = 0; k < 64; k++) send((k * 5) % 64, img[(k * 5) % 64]);
    expect_done("stride", 0, 100);
  endtask

  task automatic t_reverse_dups();
    std_image();
    img[9] = 8'h75; img[23] = 8'hFF; img[5] = 8'h02;
    img[63] = sum62();
    target_tenths = 8'd80;
    do_clear();
    send(70, 8'h55);
    send(200, 8'h99);
    send(5, img[5]);
    for (int i = 63; i >= 0; i--) begin
      if (i == 5) send(5, 8'h77);
      else if (i != 0) send(i, img[i]);
    end
    send(3, 8'h21);
    chk("R4 duplicate before done keeps row", int'(row_bits), int'(img[3]));
    chk("R5 R4 no done before last index", int'(done), 0);
    send(0, img[0]);
    expect_done("reverse", 1, 80);
    send(3, 8'h21);
    chk("R4 duplicate after done keeps row", int'(row_bits), int'(img[3]));
    @(negedge clk);
    chk("R3 no second done", int'(done), 0);
    chk("R2 ok holds after done", int'(checksum_ok), 1);
  endtask

  task automatic t_clear_midstream();
    std_image();
    target_tenths = 8'd99;
    do_clear();
    for (int i = 0; i < 40; i++) send(i, 8'h33);
    do_clear();
    chk("R11 fields cleared", int'(module_banks), 0);
    for (int i = 0; i < 64; i++) send(i, img[i]);
    expect_done("clearmid R11", 1, 99);
  endtask

  task automatic t_cl3_only();
    std_image();
    img[18] = 8'h04;
    img[63] = sum62();
    target_tenths = 8'd100;
    do_clear();
    for (int i = 0; i < 64; i++) send(63 - i, img[63 - i]);
    expect_done("cl3only", 1, 100);
  endtask

  task automatic t_clear_priority();
    std_image();
    do_clear();
    for (int i = 0; i < 63; i++) send(i, img[i]);
    clr = 1'b1; byte_valid = 1'b1; byte_idx = 8'd63; byte_data = img[63];
    @(negedge clk);
    clr = 1'b0; byte_valid = 1'b0;
    @(negedge clk);
    chk("R1 clear beats strobe", int'(done), 0);
    chk("R1 clear beats strobe row", int'(row_bits), 0);
  endtask

  logic finished = 1'b0;

  initial begin
    rst = 1'b1; clr = 1'b0; byte_valid = 1'b0;
    byte_idx = 8'd0; byte_data = 8'd0; target_tenths = 8'd100;
    @(negedge clk);
    t_reset();
    t_in_order();
    t_stride_bad_sum();
    t_reverse_dups();
    t_clear_midstream();
    t_cl3_only();
    t_clear_priority();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule